// File: doc/BRIEF.md
# Stereo Voice Sample FIFO Host Port

This block is the host-facing front end of a voice playback and capture engine. A microcontroller reaches it through a 16-bit strobed port with chip select, write strobe, read strobe and a data/command select. Data writes fill a left and a right sample FIFO, each 256 words of 16 bits. Command writes set the operating mode, stereo and DMA options, and the polarity of the handshake pins. Status reads return the flags of both FIFOs. A pop interface on the other side stands in for the synthesizer. It drains the FIFOs during playback, and only after the FIFO has first filled past half. During capture a push interface fills the left FIFO, and the host reads it back.

Three flag pins (empty, more-than-half, full) report one FIFO at a time. In stereo mode without DMA, a channel pin picks which FIFO they report. A DMA path with request and acknowledge pins can move samples instead of the host strobes. In stereo DMA mode, the full pin becomes the right-channel request and the channel pin becomes the right-channel acknowledge. An active-low busy pin shows that the engine is playing, capturing or paused.

Top module: `voice_fifo_host`

## Requirements
- R1: Host write and read strobes take effect on their rising edge, and only if `cs_n_i` is low at that edge. A strobe whose rising edge sees `cs_n_i` high changes nothing.
- R2: When `dc_i` is low, a write loads the command byte from `din_i[7:0]`, and a read returns the status byte on `dout_o` as {active, 0, full_R, mid_R, empty_R, full_L, mid_L, empty_L} (bit 7 down to bit 0). Active is 1 when the mode is not idle. When `dc_i` is high, writes push a sample and reads return and pop the head of the left FIFO.
- R3: Per FIFO, empty means a count of 0, mid means a count of 129 or more, and full means a count of 256. The flags follow the count in the same cycle as the count.
- R4: A sample write to a full FIFO is dropped. Samples leave each FIFO in the order they entered.
- R5: In playback (mode 01), consumer pops are ignored until the mid flag has been active: the left FIFO in mono, both FIFOs in stereo. Pops are then accepted until the mode becomes idle or record. `play_run_o` shows this state.
- R6: In stereo mode (command bit 2) without DMA, `ch_sel_i` high makes the flag pins report the right FIFO, and low makes them report the left FIFO. In mono or record mode the flags report the left FIFO. In stereo mode, host sample writes alternate left, right, left, and so on, starting from left after every command write.
- R7: The command fields are: bits [1:0] mode (00 idle, 01 playback, 10 record, 11 pause), bit 2 stereo, bit 3 DMA, bit 4 invert empty, bit 5 invert mid, bit 6 invert full, bit 7 invert handshake (both requests and both acknowledges). The defaults are active-high flags and requests and active-low acknowledges.
- R8: With DMA enabled in playback, the left request becomes active one cycle after the left FIFO is below mid. It stays active until the FIFO is full, and drops one cycle later. DMA write strobes take effect on their rising edge only while the left acknowledge is active.
- R9: In stereo DMA playback, `full_o` carries the right request, which follows the same rule as the left request. `ch_sel_i` serves as the right acknowledge, and a DMA write with only the right acknowledge active goes to the right FIFO.
- R10: `busy_n_o` is low whenever the mode is playback, record or pause, and high when the mode is idle.
- R11: In record mode, `cap_push_i` pushes `cap_data_i` into the left FIFO. A command write with mode idle empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Host chip select, active low |
| wr_n_i | input | 1 | Host write strobe, acts on rising edge |
| rd_n_i | input | 1 | Host read strobe, acts on rising edge |
| dc_i | input | 1 | 1 = sample data, 0 = command/status |
| din_i | input | 16 | Host and DMA write data |
| dout_o | output | 16 | Read data: left FIFO head or status byte |
| ch_sel_i | input | 1 | Flag channel select; right acknowledge in stereo DMA |
| empty_o | output | 1 | Empty flag of the selected FIFO |
| mid_o | output | 1 | More-than-half flag of the selected FIFO |
| full_o | output | 1 | Full flag, or right request in stereo DMA |
| busy_n_o | output | 1 | Low while the engine is active |
| dreq_l_o | output | 1 | Left DMA request |
| dack_l_i | input | 1 | Left DMA acknowledge |
| dma_wr_n_i | input | 1 | DMA write strobe |
| dma_rd_n_i | input | 1 | DMA read strobe |
| cap_push_i | input | 1 | Capture sample push (record mode) |
| cap_data_i | input | 16 | Capture sample |
| pop_l_i | input | 1 | Consumer pop, left |
| pop_r_i | input | 1 | Consumer pop, right |
| smp_l_o | output | 16 | Left FIFO head |
| smp_r_o | output | 16 | Right FIFO head |
| play_run_o | output | 1 | Consumer pops are being accepted |

## Verification
A strobe takes effect at the first clock edge that sees it high again. From that edge, the counts, the flag pins, the status byte, `busy_n_o` and the FIFO heads are due at once. The playback gate and both DMA requests are registered from the counts, so they are due one edge later. The bench drives every input on the falling clock edge and samples outputs on a later falling edge. For the gate and the requests it waits one more falling edge before sampling. Consumer pops are checked one sample per cycle against the sequence that was written.

// File: rtl/avf_pkg.sv
`timescale 1ns/1ps
package avf_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_PLAY  = 2'b01,
        MODE_REC   = 2'b10,
        MODE_PAUSE = 2'b11
    } mode_e;

    // Command byte, MSB first: polarity bits, DMA, stereo, mode
    typedef struct packed {
        logic  inv_hs;
        logic  inv_full;
        logic  inv_mid;
        logic  inv_empty;
        logic  dma;
        logic  stereo;
        mode_e mode;
    } cmd_t;

    typedef struct packed {
        cmd_t cmd;
        logic side;   // next stereo host write goes right when set
        logic run;    // playback gate opened
        logic req_l;
        logic req_r;
    } ctl_t;
endpackage

// File: rtl/avf_edge.sv
`timescale 1ns/1ps
module avf_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb_n_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = strb_n_i;
        rise_o = ~prev_q & strb_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/avf_fifo.sv
`timescale 1ns/1ps
module avf_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic do_push, do_pop;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push_i && (ptr_q.cnt != CW'(DEPTH)) && !flush_i;
        do_pop  = pop_i && (ptr_q.cnt != '0) && !flush_i;
        if (flush_i) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wp = ptr_q.wp + AW'(1);
            if (do_pop)  ptr_d.rp = ptr_q.rp + AW'(1);
            ptr_d.cnt = ptr_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[ptr_q.wp] <= wdata_i;
    end

    assign rdata_o = mem[ptr_q.rp];
    assign count_o = ptr_q.cnt;
endmodule

// File: rtl/voice_fifo_host.sv
`timescale 1ns/1ps
module voice_fifo_host
    import avf_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          wr_n_i,
    input  logic          rd_n_i,
    input  logic          dc_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    input  logic          ch_sel_i,
    output logic          empty_o,
    output logic          mid_o,
    output logic          full_o,
    output logic          busy_n_o,
    output logic          dreq_l_o,
    input  logic          dack_l_i,
    input  logic          dma_wr_n_i,
    input  logic          dma_rd_n_i,
    input  logic          cap_push_i,
    input  logic [DW-1:0] cap_data_i,
    input  logic          pop_l_i,
    input  logic          pop_r_i,
    output logic [DW-1:0] smp_l_o,
    output logic [DW-1:0] smp_r_o,
    output logic          play_run_o
);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int MID_LVL = DEPTH / 2 + 1;
    localparam int NCH     = 2;

    ctl_t s_d, s_q;

    logic [3:0]    rise;
    logic [NCH-1:0] push, pop, emp, mid, ful;
    logic [DW-1:0] wdata [NCH];
    logic [DW-1:0] head  [NCH];
    logic [CW-1:0] cnt   [NCH];
    logic          flush;

    logic host_wr, host_rd, cmd_wr, dat_wr, dat_rd;
    logic ack_l, ack_r, sdma, dma_wr, dma_rd, dma_wr_l, dma_wr_r;
    logic is_rec, is_play, playing, to_right, use_r;
    logic [7:0] status;

    avf_edge #(.N(4)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_n_i ({dma_rd_n_i, dma_wr_n_i, rd_n_i, wr_n_i}),
        .rise_o   (rise)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        avf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush),
            .push_i  (push[c]),
            .wdata_i (wdata[c]),
            .pop_i   (pop[c]),
            .rdata_o (head[c]),
            .count_o (cnt[c])
        );
        assign emp[c] = (cnt[c] == '0);
        assign mid[c] = (cnt[c] >= CW'(MID_LVL));
        assign ful[c] = (cnt[c] == CW'(DEPTH));
    end

    // decode of strobes and handshakes
    always_comb begin
        host_wr  = rise[0] && !cs_n_i;
        host_rd  = rise[1] && !cs_n_i;
        cmd_wr   = host_wr && !dc_i;
        dat_wr   = host_wr && dc_i;
        dat_rd   = host_rd && dc_i;
        is_rec   = (s_q.cmd.mode == MODE_REC);
        is_play  = (s_q.cmd.mode == MODE_PLAY);
        playing  = is_play && s_q.run;
        ack_l    = s_q.cmd.inv_hs ? dack_l_i : !dack_l_i;
        ack_r    = s_q.cmd.inv_hs ? ch_sel_i : !ch_sel_i;
        sdma     = s_q.cmd.dma && s_q.cmd.stereo;
        dma_wr   = s_q.cmd.dma && rise[2];
        dma_rd   = s_q.cmd.dma && rise[3];
        dma_wr_l = dma_wr && ack_l;
        dma_wr_r = dma_wr && sdma && ack_r && !ack_l;
        to_right = s_q.cmd.stereo && s_q.side;
        flush    = cmd_wr && (din_i[1:0] == MODE_IDLE);

        // host strobes take priority over a DMA strobe in the same cycle
        push[0]  = is_rec ? cap_push_i
                          : ((dat_wr && !to_right) || (!dat_wr && dma_wr_l));
        push[1]  = !is_rec && ((dat_wr && to_right) || (!dat_wr && dma_wr_r));
        wdata[0] = is_rec ? cap_data_i : din_i;
        wdata[1] = din_i;
        pop[0]   = dat_rd || (dma_rd && ack_l) || (pop_l_i && playing);
        pop[1]   = pop_r_i && playing && s_q.cmd.stereo;
    end

    // next-state computation
    always_comb begin
        s_d = s_q;
        if (cmd_wr) begin
            s_d.cmd  = cmd_t'(din_i[7:0]);
            s_d.side = 1'b0;
        end else if (dat_wr && s_q.cmd.stereo) begin
            s_d.side = !s_q.side;
        end
        s_d.run   = (is_play || s_q.cmd.mode == MODE_PAUSE)
                 && (s_q.run || (mid[0] && (!s_q.cmd.stereo || mid[1])));
        s_d.req_l = s_q.cmd.dma
                 && ((is_play && (s_q.req_l ? !ful[0] : !mid[0]))
                  || (is_rec && !emp[0]));
        s_d.req_r = sdma && is_play && (s_q.req_r ? !ful[1] : !mid[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // pin outputs
    always_comb begin
        use_r      = s_q.cmd.stereo && !s_q.cmd.dma && !is_rec && ch_sel_i;
        empty_o    = (use_r ? emp[1] : emp[0]) ^ s_q.cmd.inv_empty;
        mid_o      = (use_r ? mid[1] : mid[0]) ^ s_q.cmd.inv_mid;
        full_o     = sdma ? (s_q.req_r ^ s_q.cmd.inv_hs)
                          : ((use_r ? ful[1] : ful[0]) ^ s_q.cmd.inv_full);
        dreq_l_o   = s_q.req_l ^ s_q.cmd.inv_hs;
        busy_n_o   = (s_q.cmd.mode == MODE_IDLE);
        status     = {s_q.cmd.mode != MODE_IDLE, 1'b0,
                      ful[1], mid[1], emp[1], ful[0], mid[0], emp[0]};
        dout_o     = dc_i ? head[0] : {{(DW-8){1'b0}}, status};
        smp_l_o    = head[0];
        smp_r_o    = head[1];
        play_run_o = playing;
    end
endmodule

// File: rtl/avf_host_chk.sv
`timescale 1ns/1ps
module avf_host_chk #(
    parameter int CW    = 9,
    parameter int DEPTH = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic [7:0]    cmd,
    input logic          run,
    input logic          req_l,
    input logic [CW-1:0] cnt_l,
    input logic          pop_l,
    input logic          flush
);
    localparam int MID_LVL = DEPTH / 2 + 1;

    // R1
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cmd));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_l <= CW'(DEPTH));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_l == CW'(DEPTH) && !pop_l && !flush) |=> (cnt_l == CW'(DEPTH)));

    // R5
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(cnt_l >= CW'(MID_LVL)));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_l && cnt_l == CW'(DEPTH)) |=> !req_l);
endmodule

bind voice_fifo_host avf_host_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n_i),
    .cmd   (s_q.cmd),
    .run   (s_q.run),
    .req_l (s_q.req_l),
    .cnt_l (cnt[0]),
    .pop_l (pop[0]),
    .flush (flush)
);

// File: tb/voice_fifo_host_bench.sv
`timescale 1ns/1ps
module voice_fifo_host_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dc = 1'b0;
    logic [15:0] din = '0, dout;
    logic ch_sel = 1'b0;
    logic empty, mid, full, busy_n, dreq_l;
    logic dack_l = 1'b1, dma_wr_n = 1'b1, dma_rd_n = 1'b1;
    logic cap_push = 1'b0;
    logic [15:0] cap_data = '0;
    logic pop_l = 1'b0, pop_r = 1'b0;
    logic [15:0] smp_l, smp_r;
    logic play_run;
    int checks = 0, errors = 0;

    always #4 clk = !clk;

    voice_fifo_host u_voice_fifo_host (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_n_i(wr_n), .rd_n_i(rd_n),
        .dc_i(dc), .din_i(din), .dout_o(dout), .ch_sel_i(ch_sel),
        .empty_o(empty), .mid_o(mid), .full_o(full), .busy_n_o(busy_n),
        .dreq_l_o(dreq_l), .dack_l_i(dack_l), .dma_wr_n_i(dma_wr_n),
        .dma_rd_n_i(dma_rd_n), .cap_push_i(cap_push), .cap_data_i(cap_data),
        .pop_l_i(pop_l), .pop_r_i(pop_r), .smp_l_o(smp_l), .smp_r_o(smp_r),
        .play_run_o(play_run)
    );

    task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", what, got, exp);
        end
    endtask

    task automatic host_write(input logic dsel, input logic [15:0] d, input logic csv = 1'b0);
        @(negedge clk); cs_n = csv; dc = dsel; din = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic host_read(input logic dsel, output logic [15:0] d);
        @(negedge clk); cs_n = 1'b0; dc = dsel; rd_n = 1'b0;
        @(negedge clk); d = dout; rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic dma_write(input logic [15:0] d);
        @(negedge clk); din = d; dma_wr_n = 1'b0;
        @(negedge clk); dma_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 busy_n after reset", 16'(busy_n), 16'h1);
        chk("R3 empty after reset", 16'(empty), 16'h1);
        chk("R3 mid after reset", 16'(mid), 16'h0);
        chk("R3 full after reset", 16'(full), 16'h0);
        chk("R8 dreq after reset", 16'(dreq_l), 16'h0);
    endtask

    task automatic t_mono_play;
        int bad = 0;
        host_write(1'b0, 16'h0001);
        chk("R10 busy_n in playback", 16'(busy_n), 16'h0);
        for (int i = 0; i < 128; i++) host_write(1'b1, 16'hA000 + 16'(i));
        chk("R3 mid at 128", 16'(mid), 16'h0);
        chk("R3 empty at 128", 16'(empty), 16'h0);
        @(negedge clk); pop_l = 1'b1;
        @(negedge clk); pop_l = 1'b0;
        chk("R5 pop ignored before mid", smp_l, 16'hA000);
        chk("R5 gate closed", 16'(play_run), 16'h0);
        host_write(1'b1, 16'hA080);
        chk("R3 mid at 129", 16'(mid), 16'h1);
        @(negedge clk);
        chk("R5 gate open after mid", 16'(play_run), 16'h1);
        for (int i = 129; i < 256; i++) host_write(1'b1, 16'hA000 + 16'(i));
        chk("R3 full at 256", 16'(full), 16'h1);
        host_write(1'b1, 16'hBEEF);
        chk("R4 still full after extra write", 16'(full), 16'h1);
        @(negedge clk); pop_l = 1'b1;
        for (int i = 0; i < 256; i++) begin
            if (smp_l !== 16'hA000 + 16'(i)) bad++;
            @(negedge clk);
        end
        pop_l = 1'b0;
        chk("R4 pop order mismatches", 16'(bad), 16'h0);
        chk("R4 empty after 256 pops", 16'(empty), 16'h1);
    endtask

    task automatic t_cs_ignore;
        host_write(1'b0, 16'h0000, 1'b1);
        chk("R1 command ignored with cs high", 16'(busy_n), 16'h0);
        host_write(1'b1, 16'h1234, 1'b1);
        chk("R1 data ignored with cs high", 16'(empty), 16'h1);
    endtask

    task automatic t_polarity;
        host_write(1'b0, 16'h0071);
        chk("R7 empty inverted", 16'(empty), 16'h0);
        chk("R7 mid inverted", 16'(mid), 16'h1);
        chk("R7 full inverted", 16'(full), 16'h1);
    endtask

    task automatic t_stereo;
        logic [15:0] st;
        host_write(1'b0, 16'h0000);
        host_write(1'b0, 16'h0005);
        host_write(1'b1, 16'h1111);
        @(negedge clk); ch_sel = 1'b0; #1;
        chk("R6 left selected not empty", 16'(empty), 16'h0);
        ch_sel = 1'b1; #1;
        chk("R6 right selected empty", 16'(empty), 16'h1);
        ch_sel = 1'b0;
        host_read(1'b0, st);
        chk("R2 status byte", st, 16'h0088);
        host_write(1'b1, 16'h2222);
        @(negedge clk); ch_sel = 1'b1; #1;
        chk("R6 second write went right", 16'(empty), 16'h0);
        chk("R6 right head", smp_r, 16'h2222);
        host_write(1'b0, 16'h0000);
        host_write(1'b0, 16'h0001);
        host_write(1'b1, 16'h3333);
        #1;
        chk("R6 mono ignores channel pin", 16'(empty), 16'h0);
        ch_sel = 1'b0;
    endtask

    task automatic t_record;
        logic [15:0] d;
        host_write(1'b0, 16'h0000);
        host_write(1'b0, 16'h0002);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); cap_push = 1'b1; cap_data = 16'hC000 + 16'(i);
        end
        @(negedge clk); cap_push = 1'b0;
        host_read(1'b1, d);
        chk("R11 first captured sample", d, 16'hC000);
        host_read(1'b1, d);
        chk("R11 second captured sample", d, 16'hC001);
        host_write(1'b0, 16'h0000);
        chk("R11 idle command flushes", 16'(empty), 16'h1);
    endtask

    task automatic t_dma;
        host_write(1'b0, 16'h0009);
        @(negedge clk);
        chk("R8 request when below mid", 16'(dreq_l), 16'h1);
        dma_write(16'hDEAD);
        chk("R8 DMA write without ack ignored", 16'(empty), 16'h1);
        dack_l = 1'b0;
        for (int i = 0; i < 256; i++) begin
            dma_write(16'hD000 + 16'(i));
            if (i == 199) chk("R8 request holds past mid", 16'(dreq_l), 16'h1);
        end
        @(negedge clk);
        chk("R8 request drops at full", 16'(dreq_l), 16'h0);
        chk("R3 full after DMA fill", 16'(full), 16'h1);
        dack_l = 1'b1;
    endtask

    task automatic t_stereo_dma;
        logic [15:0] st;
        host_write(1'b0, 16'h0000);
        host_write(1'b0, 16'h000D);
        @(negedge clk);
        chk("R9 right request on full pin", 16'(full), 16'h1);
        ch_sel = 1'b0;
        dma_write(16'h5555);
        host_read(1'b0, st);
        chk("R9 DMA write went right", st, 16'h0081);
        ch_sel = 1'b1;
    endtask

    task automatic t_hs_invert;
        host_write(1'b0, 16'h0000);
        host_write(1'b0, 16'h0089);
        @(negedge clk);
        chk("R7 request active low", 16'(dreq_l), 16'h0);
        dack_l = 1'b1;
        dma_write(16'h7777);
        chk("R7 ack active high accepted", 16'(empty), 16'h0);
        ch_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mono_play();
        t_cs_ignore();
        t_polarity();
        t_stereo();
        t_record();
        t_dma();
        t_stereo_dma();
        t_hs_invert();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule